// File: doc/BRIEF.md
# Transmit-Empty Interrupt Generator with Holdoff

This block decides when a UART-style transmitter with a 16-entry FIFO raises its "transmit buffer empty" interrupt. It watches the FIFO occupancy, and each time the occupancy drops to zero it either raises the indication at once or holds it off. The holdoff lasts one character time less the final stop bit. The indication is immediate when the FIFO held two or more bytes at the same time since the last empty event, or when this is the first empty event since FIFO mode was switched on. Otherwise the holdoff applies, so that a host that feeds the transmitter one byte at a time does not see an interrupt before the byte has nearly left the line.

The holdoff is timed in baud ticks. The surrounding logic supplies the character length and the stop-bit length in ticks, and a one-cycle tick strobe. The pending condition is removed by a host write to the transmit holding register, or by a read of the identification register while this source is the one being reported. The block's outputs are the gated interrupt request and its identification code. Arbitration against other interrupt sources happens outside the block.

Top module: `txe_irq_gen`

## Requirements
- R1: While `fifo_en_i` is low, `tx_irq_o` is low from the next cycle on, and empty events seen while disabled raise nothing.
- R2: `tx_code_o` is 4'h2 whenever `tx_irq_o` is high, and 4'h0 otherwise.
- R3: A cycle with `thr_wr_i` high clears the pending condition and cancels a running holdoff. Clearing wins over setting in the same cycle.
- R4: A cycle with `iir_rd_i` and `iir_src_tx_i` both high clears the pending condition. `iir_rd_i` with `iir_src_tx_i` low has no effect.
- R5: When `tx_level_i` becomes 0 after having been 2 or more since the previous empty event, `tx_irq_o` rises on the clock edge that samples the zero occupancy.
- R6: Otherwise an empty event starts a holdoff of L = `char_ticks_i` − `stop_ticks_i` baud ticks, and `tx_irq_o` rises on the edge that samples the L-th `baud_tick_i` after the event. If `char_ticks_i` ≤ `stop_ticks_i`, the indication is immediate.
- R7: The first empty event after a `fifo_en_rise_i` pulse raises `tx_irq_o` with no holdoff. This covers a FIFO that is already empty at the rise and one that empties later.
- R8: The two-or-more record is cleared at every empty event, so that a refill with one byte followed by an empty event is held off again.
- R9: `tx_ie_i` masks only the output. A condition that became pending while `tx_ie_i` was low appears on `tx_irq_o` once `tx_ie_i` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode enabled |
| fifo_en_rise_i | input | 1 | One-cycle pulse when FIFO mode is switched on |
| tx_ie_i | input | 1 | Transmit interrupt enable |
| tx_level_i | input | LVL_W (5) | Transmit FIFO occupancy, 0 to 16 |
| thr_wr_i | input | 1 | Host write to the transmit holding register |
| iir_rd_i | input | 1 | Host read of the identification register |
| iir_src_tx_i | input | 1 | The arbiter is presenting the transmit-empty code at this read |
| baud_tick_i | input | 1 | Baud tick strobe |
| char_ticks_i | input | CNT_W (12) | Character length in baud ticks |
| stop_ticks_i | input | CNT_W (12) | Final stop bit length in baud ticks |
| tx_irq_o | output | 1 | Transmit-empty interrupt request |
| tx_code_o | output | 4 | Identification code: 4'h2 when requesting, else 4'h0 |

## Verification
The bound checker covers these rules on every cycle:
- disabling FIFO mode, a transmit write and an acknowledged identification read each leave the request low on the next cycle;
- the code output agrees with the request;
- a running holdoff never holds a zero count.

The timing rules can only be shown by bench scenarios that drive occupancy histories and count baud ticks. These are the holdoff length, the immediate path after two or more bytes, the first event after enable, the re-arming of the two-or-more record and the masking by the enable.

// File: rtl/txe_pkg.sv
package txe_pkg;
  typedef logic [3:0] iir_code_t;
  localparam iir_code_t CODE_NONE = 4'h0;
  localparam iir_code_t CODE_TXE  = 4'h2;
endpackage

// File: rtl/txe_edge_track.sv
module txe_edge_track #(
  parameter int LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             fifo_en_rise_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             trig_o,
  output logic             imm_o
);
  localparam logic [LVL_W-1:0] MULTI_LVL = LVL_W'(2);

  logic empty_now, empty_q, multi_q, first_q;

  assign empty_now = (level_i == '0);
  // empty event: fresh zero occupancy, or FIFO switched on while already empty
  assign trig_o = fifo_en_i & empty_now & (~empty_q | fifo_en_rise_i);
  assign imm_o  = first_q | fifo_en_rise_i | multi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b0;
      multi_q <= 1'b0;
      first_q <= 1'b0;
    end else begin
      empty_q <= empty_now;
      if (!fifo_en_i || trig_o) multi_q <= 1'b0;
      else if (level_i >= MULTI_LVL) multi_q <= 1'b1;
      if (trig_o) first_q <= 1'b0;
      else if (fifo_en_rise_i) first_q <= 1'b1;
    end
  end
endmodule

// File: rtl/txe_holdoff.sv
module txe_holdoff #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cancel_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             done_o,
  output logic             act_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             act_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o = act_q & tick_i & (cnt_q == CNT_W'(1));
  assign act_o  = act_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (cancel_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      act_q <= 1'b1;
      cnt_q <= load_val_i;
    end else if (act_q && tick_i) begin
      if (done_o) act_q <= 1'b0;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/txe_irq_gen.sv
module txe_irq_gen
  import txe_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             fifo_en_rise_i,
  input  logic             tx_ie_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic             thr_wr_i,
  input  logic             iir_rd_i,
  input  logic             iir_src_tx_i,
  input  logic             baud_tick_i,
  input  logic [CNT_W-1:0] char_ticks_i,
  input  logic [CNT_W-1:0] stop_ticks_i,
  output logic             tx_irq_o,
  output logic [3:0]       tx_code_o
);
  logic             trig, imm, imm_all, clr, set;
  logic             hold_done, hold_act;
  logic [CNT_W-1:0] hold_len, hold_cnt;
  logic             pending_q;

  assign hold_len = (char_ticks_i > stop_ticks_i) ? (char_ticks_i - stop_ticks_i) : '0;
  assign imm_all  = imm | (hold_len == '0);
  assign clr      = thr_wr_i | (iir_rd_i & iir_src_tx_i) | ~fifo_en_i;
  assign set      = (trig & imm_all) | hold_done;

  txe_edge_track #(.LVL_W(LVL_W)) u_track (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fifo_en_i      (fifo_en_i),
    .fifo_en_rise_i (fifo_en_rise_i),
    .level_i        (tx_level_i),
    .trig_o         (trig),
    .imm_o          (imm)
  );

  txe_holdoff #(.CNT_W(CNT_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cancel_i   (thr_wr_i | ~fifo_en_i),
    .load_i     (trig & ~imm_all),
    .load_val_i (hold_len),
    .tick_i     (baud_tick_i),
    .done_o     (hold_done),
    .act_o      (hold_act),
    .cnt_o      (hold_cnt)
  );

  // clear has priority over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pending_q <= 1'b0;
    else if (clr)   pending_q <= 1'b0;
    else if (set)   pending_q <= 1'b1;
  end

  assign tx_irq_o  = pending_q & fifo_en_i & tx_ie_i;
  assign tx_code_o = tx_irq_o ? CODE_TXE : CODE_NONE;
endmodule

// File: rtl/txe_irq_gen_chk.sv
module txe_irq_gen_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             thr_wr_i,
  input logic             iir_rd_i,
  input logic             iir_src_tx_i,
  input logic             tx_irq_o,
  input logic [3:0]       tx_code_o,
  input logic             hold_act,
  input logic [CNT_W-1:0] hold_cnt
);
  a_r1_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |=> !tx_irq_o);
  a_r2_code_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o ? (tx_code_o == 4'h2) : (tx_code_o == 4'h0));
  a_r3_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> !tx_irq_o);
  a_r4_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && iir_src_tx_i) |=> !tx_irq_o);
  a_r6_cnt_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_act |-> (hold_cnt != '0));
endmodule

bind txe_irq_gen txe_irq_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_en_i    (fifo_en_i),
  .thr_wr_i     (thr_wr_i),
  .iir_rd_i     (iir_rd_i),
  .iir_src_tx_i (iir_src_tx_i),
  .tx_irq_o     (tx_irq_o),
  .tx_code_o    (tx_code_o),
  .hold_act     (hold_act),
  .hold_cnt     (hold_cnt)
);

// File: tb/txe_irq_gen_test.sv
module txe_irq_gen_test;
  localparam int LVL_W = 5;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fifo_en = 0, rise = 0, ie = 0, thr_wr = 0, rd = 0, src = 0, tick = 0;
  logic [LVL_W-1:0] lvl = '0;
  logic [CNT_W-1:0] chr = 12'd5, stp = 12'd1;
  logic irq;
  logic [3:0] code;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  txe_irq_gen #(.LVL_W(LVL_W), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_en_i(fifo_en), .fifo_en_rise_i(rise),
    .tx_ie_i(ie), .tx_level_i(lvl), .thr_wr_i(thr_wr), .iir_rd_i(rd),
    .iir_src_tx_i(src), .baud_tick_i(tick), .char_ticks_i(chr),
    .stop_ticks_i(stp), .tx_irq_o(irq), .tx_code_o(code)
  );

  // reference model written from the requirements
  logic m_pend, m_empq, m_multi, m_first, m_hold;
  logic [CNT_W-1:0] m_cnt;

  function automatic logic [CNT_W-1:0] hold_len(logic [CNT_W-1:0] c, logic [CNT_W-1:0] s);
    return (c > s) ? c - s : '0;
  endfunction

  function automatic logic [3:0] exp_code(logic p, logic e, logic i);
    return (p && e && i) ? 4'h2 : 4'h0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pend = 0; m_empq = 0; m_multi = 0; m_first = 0; m_hold = 0; m_cnt = '0;
    end else begin
      logic empty, trig, imm, set, clr;
      logic [CNT_W-1:0] l;
      l     = hold_len(chr, stp);
      empty = (lvl == 0);
      trig  = fifo_en && empty && (!m_empq || rise);
      imm   = m_first || rise || m_multi || (l == 0);
      clr   = thr_wr || (rd && src) || !fifo_en;
      set   = (trig && imm) || (m_hold && tick && m_cnt == 1);
      if (!fifo_en || thr_wr) m_hold = 0;
      else if (trig && !imm) begin m_hold = 1; m_cnt = l; end
      else if (m_hold && tick) begin
        if (m_cnt == 1) m_hold = 0;
        m_cnt = m_cnt - 1;
      end
      if (clr) m_pend = 0; else if (set) m_pend = 1;
      if (!fifo_en || trig) m_multi = 0; else if (lvl >= 2) m_multi = 1;
      if (trig) m_first = 0; else if (rise) m_first = 1;
      m_empq = empty;
    end
  end

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick = 1; cyc(); tick = 0; cyc(); end
  endtask
  task automatic wr_to(logic [LVL_W-1:0] v);
    thr_wr = 1; lvl = v; cyc(); thr_wr = 0;
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    repeat (3) cyc();
    rst_ni = 1; cyc();
    check("R2 reset irq", {3'b0, irq}, 4'h0);
    check("R2 reset code", code, 4'h0);

    fifo_en = 1; rise = 1; ie = 1; cyc(); rise = 0;
    check("R7 first after enable, empty", {3'b0, irq}, 4'h1);
    check("R2 code 2h", code, 4'h2);

    wr_to(1);
    check("R3 write clears", {3'b0, irq}, 4'h0);
    lvl = 0; cyc();
    check("R6 holdoff started", {3'b0, irq}, 4'h0);
    ticks(3);
    check("R6 not before L ticks", {3'b0, irq}, 4'h0);
    ticks(1);
    check("R6 raised at L-th tick", {3'b0, irq}, 4'h1);

    wr_to(2); lvl = 1; cyc(); lvl = 0; cyc();
    check("R5 immediate after two bytes", {3'b0, irq}, 4'h1);

    wr_to(1); lvl = 0; cyc();
    check("R8 record cleared, held off", {3'b0, irq}, 4'h0);
    ticks(4);
    check("R8 raised after holdoff", {3'b0, irq}, 4'h1);

    wr_to(1); lvl = 0; cyc(); ticks(2);
    thr_wr = 1; cyc(); thr_wr = 0;
    ticks(4);
    check("R3 write cancels holdoff", {3'b0, irq}, 4'h0);

    wr_to(2); lvl = 0; cyc();
    rd = 1; src = 0; cyc(); rd = 0;
    check("R4 read without source ignored", {3'b0, irq}, 4'h1);
    rd = 1; src = 1; cyc(); rd = 0; src = 0;
    check("R4 read with source clears", {3'b0, irq}, 4'h0);

    wr_to(2); ie = 0; lvl = 0; cyc();
    check("R9 masked by enable", {3'b0, irq}, 4'h0);
    ie = 1; cyc();
    check("R9 pending shown after enable", {3'b0, irq}, 4'h1);

    fifo_en = 0; cyc();
    check("R1 disable clears", {3'b0, irq}, 4'h0);
    wr_to(2); lvl = 0; cyc();
    check("R1 events ignored while disabled", {3'b0, irq}, 4'h0);
    fifo_en = 1; rise = 1; cyc(); rise = 0;
    check("R7 immediate on re-enable", {3'b0, irq}, 4'h1);

    fifo_en = 0; lvl = 1; cyc();
    fifo_en = 1; rise = 1; cyc(); rise = 0;
    check("R7 nothing while non-empty", {3'b0, irq}, 4'h0);
    lvl = 0; cyc();
    check("R7 first event no holdoff", {3'b0, irq}, 4'h1);

    stp = 12'd5;
    wr_to(1); lvl = 0; cyc();
    check("R6 zero holdoff immediate", {3'b0, irq}, 4'h1);
    stp = 12'd1;

    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 99) < 2) begin
        rise = !fifo_en; fifo_en = !fifo_en;
      end else rise = 0;
      if ($urandom_range(0, 99) < 3) ie = !ie;
      if ($urandom_range(0, 99) < 30)
        lvl = ($urandom_range(0, 9) == 0) ? LVL_W'(16) : LVL_W'($urandom_range(0, 3));
      thr_wr = ($urandom_range(0, 99) < 8);
      rd     = ($urandom_range(0, 99) < 8);
      src    = $urandom_range(0, 1) != 0;
      tick   = ($urandom_range(0, 99) < 35);
      if ($urandom_range(0, 199) == 0) begin
        chr = CNT_W'($urandom_range(1, 9));
        stp = CNT_W'($urandom_range(0, 2));
      end
      cyc();
      check("R5/R6 random vs model", {3'b0, irq}, {3'b0, m_pend & fifo_en & ie});
      check("R2 random code", code, exp_code(m_pend, fifo_en, ie));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule